// File: doc/BRIEF.md
# Interrupt Redirection and Dispatch Unit

This block watches a bank of interrupt input pins and turns each new assertion into one delivery message for a set of processor targets. Every pin has a redirection entry, supplied as a static input bus. When a pin rises, the block reads that pin's entry. A masked entry is dropped. An unmasked entry yields a message that carries the destination, the vector, the delivery mode, the destination mode, the level and the trigger mode, together with a bitmap of the targets that receive it. When the entry selects external-interrupt delivery, the vector is fetched from an external controller through a request/acknowledge handshake.

The target bitmap is resolved in one of three ways. Physical mode with destination 0xFF broadcasts to every target. Physical mode with destination k addresses target k. Logical mode selects every target whose 8-bit logical identifier shares a set bit with the destination. Lowest-priority delivery in logical mode keeps a single target out of the matching set. That target is chosen by a shared rotating offset taken modulo the match count. Lowest-priority delivery in physical mode is refused with a one-cycle error pulse.

A control state machine has four states. **IDLE** chooses the lowest pending pin and latches its entry. It moves to **DECODE** when the entry is unmasked, and stays in IDLE when the entry is masked. **DECODE** resolves the targets. It returns to IDLE on an error or an empty bitmap, moves to **EXT_WAIT** for external-interrupt delivery, and otherwise moves to **SEND**. **EXT_WAIT** holds the vector request until it is acknowledged, then moves to SEND. **SEND** presents the message until the receiver is ready, then returns to IDLE.

Top module: `irq_redirect_dispatch`

## Requirements
- R1: A dispatch starts only when a pin goes from low to high. A pin held high produces exactly one message, and lowering a pin produces no message.
- R2: When the entry's mask bit (entry bit 14) is 1, no message is produced.
- R3: The message copies the destination (entry bits 22:15), the trigger mode (bit 13), the polarity as the level (bit 12), the destination mode (bit 11, 1 = logical) and the delivery mode (bits 10:8) from the entry. For every mode other than external, the vector comes from entry bits 7:0.
- R4: Delivery mode 3'b111 (external) raises `ext_req_o` and keeps it high until `ext_ack_i` is seen. The message vector is then the `ext_vec_i` value sampled with the acknowledge.
- R5: In physical mode, destination 0xFF sets every target bit. A destination k below the target count sets only bit k. Any other destination produces no message.
- R6: Delivery mode 3'b001 (lowest priority) in physical mode produces a one-cycle `err_o` pulse and no message.
- R7: In logical mode, target t is selected when its logical identifier ANDed with the destination is nonzero.
- R8: Lowest-priority logical delivery with at least one match selects only the match at position (offset mod match count), counted from bit 0 upward. The offset starts at 0 after reset and advances by one after each such dispatch.
- R9: A dispatch whose target bitmap is empty produces no message.
- R10: Pins that rise in the same cycle are served one at a time, in ascending pin order.
- R11: While `msg_valid_o` is high and `msg_ready_i` is low, the message and its bitmap stay unchanged.
- R12: After reset, `msg_valid_o`, `err_o` and `ext_req_o` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| irq_pin_i | input | NUM_PINS | Interrupt input pins |
| redir_tab_i | input | NUM_PINS*23 | Redirection entries, with pin p at bits [p*23 +: 23] |
| tgt_lid_i | input | NUM_TGT*8 | Logical identifier of each target, with target t at bits [t*8 +: 8] |
| ext_req_o | output | 1 | Vector request to the external controller |
| ext_ack_i | input | 1 | External controller acknowledge |
| ext_vec_i | input | 8 | Vector from the external controller |
| msg_valid_o | output | 1 | Message valid |
| msg_ready_i | input | 1 | Receiver ready |
| msg_dest_o | output | 8 | Message destination |
| msg_vec_o | output | 8 | Message vector |
| msg_dlv_o | output | 3 | Message delivery mode |
| msg_dmode_o | output | 1 | Message destination mode |
| msg_level_o | output | 1 | Message level |
| msg_trig_o | output | 1 | Message trigger mode |
| msg_tgt_o | output | NUM_TGT | Target bitmap |
| err_o | output | 1 | Unsupported-mode error pulse |

## Verification
New pin edges can be captured while an earlier message is stalled in SEND, and two pins can rise in the same cycle. The bench raises pins 1 and 3 together, then checks the order of the logged vectors. It also holds ready low while a message waits, and checks that the message stays on the outputs and that nothing is logged until ready returns. A third case has the edge register's capture meet the rotating offset: four lowest-priority dispatches in a row are checked against the expected sequence of single targets.

// File: rtl/irq_disp_pkg.sv
package irq_disp_pkg;

    typedef struct packed {
        logic [7:0] dest;
        logic       mask;
        logic       trig;
        logic       pol;
        logic       dmode;
        logic [2:0] dlv;
        logic [7:0] vec;
    } irq_ent_t;

    localparam int ENT_W = $bits(irq_ent_t);

    localparam logic [2:0] DLV_FIXED  = 3'd0;
    localparam logic [2:0] DLV_LOWEST = 3'd1;
    localparam logic [2:0] DLV_EXTINT = 3'd7;

    localparam logic [7:0] DEST_ALL = 8'hFF;

    typedef enum logic [1:0] {
        S_IDLE     = 2'd0,
        S_DECODE   = 2'd1,
        S_EXT_WAIT = 2'd2,
        S_SEND     = 2'd3
    } disp_state_e;

endpackage

// File: rtl/irq_edge_pend.sv
module irq_edge_pend #(
    parameter int NUM_PINS = 8,
    localparam int IDX_W = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1
) (
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic [NUM_PINS-1:0] pin_i,
    input  logic                take_i,
    output logic                pick_valid_o,
    output logic [IDX_W-1:0]    pick_idx_o
);

    logic [NUM_PINS-1:0] pin_q;
    logic [NUM_PINS-1:0] pend_q;
    logic [NUM_PINS-1:0] rise;
    logic [NUM_PINS-1:0] clr;

    assign rise = pin_i & ~pin_q;

    // lowest set pending bit wins
    always_comb begin
        pick_idx_o = '0;
        for (int p = NUM_PINS - 1; p >= 0; p--) begin
            if (pend_q[p]) begin
                pick_idx_o = IDX_W'(p);
            end
        end
    end

    assign pick_valid_o = |pend_q;

    always_comb begin
        clr = '0;
        if (take_i) begin
            clr[pick_idx_o] = 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            pin_q  <= '0;
            pend_q <= '0;
        end else begin
            pin_q  <= pin_i;
            pend_q <= (pend_q & ~clr) | rise;
        end
    end

endmodule

// File: rtl/irq_target_sel.sv
module irq_target_sel
    import irq_disp_pkg::*;
#(
    parameter int NUM_TGT = 4,
    parameter int OFS_W   = 16
) (
    input  irq_ent_t               ent_i,
    input  logic [NUM_TGT*8-1:0]   lid_i,
    input  logic [OFS_W-1:0]       ofs_i,
    output logic [NUM_TGT-1:0]     tgt_o,
    output logic                   hit_o,
    output logic                   lp_err_o,
    output logic                   lp_adv_o
);

    logic [NUM_TGT-1:0] phys_m;
    logic [NUM_TGT-1:0] log_m;
    logic [NUM_TGT-1:0] pick_m;
    logic [OFS_W-1:0]   cnt;
    logic [OFS_W-1:0]   div;
    logic [OFS_W-1:0]   slot;
    logic [OFS_W-1:0]   run;
    logic               is_lp;
    logic               is_log;

    for (genvar t = 0; t < NUM_TGT; t++) begin : g_match
        assign log_m[t]  = |(lid_i[t*8 +: 8] & ent_i.dest);
        assign phys_m[t] = (ent_i.dest == DEST_ALL) || (ent_i.dest == 8'(t));
    end

    always_comb begin
        cnt = '0;
        for (int t = 0; t < NUM_TGT; t++) begin
            cnt = cnt + OFS_W'(log_m[t]);
        end
    end

    assign div  = (cnt == '0) ? OFS_W'(1) : cnt;
    assign slot = ofs_i % div;

    // keep the match whose rank equals slot
    always_comb begin
        pick_m = '0;
        run    = '0;
        for (int t = 0; t < NUM_TGT; t++) begin
            if (log_m[t]) begin
                if (run == slot) begin
                    pick_m[t] = 1'b1;
                end
                run = run + OFS_W'(1);
            end
        end
    end

    assign is_lp  = (ent_i.dlv == DLV_LOWEST);
    assign is_log = ent_i.dmode;

    always_comb begin
        if (is_log) begin
            tgt_o = is_lp ? pick_m : log_m;
        end else begin
            tgt_o = is_lp ? '0 : phys_m;
        end
    end

    assign hit_o    = |tgt_o;
    assign lp_err_o = is_lp && !is_log;
    assign lp_adv_o = is_lp && is_log && (|log_m);

endmodule

// File: rtl/irq_redirect_dispatch.sv
module irq_redirect_dispatch
    import irq_disp_pkg::*;
#(
    parameter int NUM_PINS = 8,
    parameter int NUM_TGT  = 4,
    parameter int OFS_W    = 16
) (
    input  logic                      clk_i,
    input  logic                      rst_ni,
    input  logic [NUM_PINS-1:0]       irq_pin_i,
    input  logic [NUM_PINS*ENT_W-1:0] redir_tab_i,
    input  logic [NUM_TGT*8-1:0]      tgt_lid_i,
    output logic                      ext_req_o,
    input  logic                      ext_ack_i,
    input  logic [7:0]                ext_vec_i,
    output logic                      msg_valid_o,
    input  logic                      msg_ready_i,
    output logic [7:0]                msg_dest_o,
    output logic [7:0]                msg_vec_o,
    output logic [2:0]                msg_dlv_o,
    output logic                      msg_dmode_o,
    output logic                      msg_level_o,
    output logic                      msg_trig_o,
    output logic [NUM_TGT-1:0]        msg_tgt_o,
    output logic                      err_o
);

    localparam int IDX_W = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1;

    disp_state_e        state_q, state_d;
    irq_ent_t           tab [NUM_PINS];
    irq_ent_t           cur_ent;
    irq_ent_t           ent_q;
    logic [NUM_TGT-1:0] tgt_q;
    logic [7:0]         vec_q;
    logic [OFS_W-1:0]   ofs_q;
    logic               take;
    logic               pick_valid;
    logic [IDX_W-1:0]   pick_idx;
    logic [NUM_TGT-1:0] sel_tgt;
    logic               sel_hit;
    logic               sel_err;
    logic               sel_adv;

    for (genvar p = 0; p < NUM_PINS; p++) begin : g_tab
        assign tab[p] = redir_tab_i[p*ENT_W +: ENT_W];
    end

    assign cur_ent = tab[pick_idx];
    assign take    = (state_q == S_IDLE) && pick_valid;

    irq_edge_pend #(
        .NUM_PINS (NUM_PINS)
    ) u_edge (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .pin_i        (irq_pin_i),
        .take_i       (take),
        .pick_valid_o (pick_valid),
        .pick_idx_o   (pick_idx)
    );

    irq_target_sel #(
        .NUM_TGT (NUM_TGT),
        .OFS_W   (OFS_W)
    ) u_sel (
        .ent_i    (ent_q),
        .lid_i    (tgt_lid_i),
        .ofs_i    (ofs_q),
        .tgt_o    (sel_tgt),
        .hit_o    (sel_hit),
        .lp_err_o (sel_err),
        .lp_adv_o (sel_adv)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: begin
                if (pick_valid && !cur_ent.mask) begin
                    state_d = S_DECODE;
                end
            end
            S_DECODE: begin
                if (sel_err || !sel_hit) begin
                    state_d = S_IDLE;
                end else if (ent_q.dlv == DLV_EXTINT) begin
                    state_d = S_EXT_WAIT;
                end else begin
                    state_d = S_SEND;
                end
            end
            S_EXT_WAIT: begin
                if (ext_ack_i) begin
                    state_d = S_SEND;
                end
            end
            S_SEND: begin
                if (msg_ready_i) begin
                    state_d = S_IDLE;
                end
            end
            default: state_d = S_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= S_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // datapath registers
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            ent_q <= '0;
            tgt_q <= '0;
            vec_q <= '0;
            ofs_q <= '0;
        end else begin
            if (take) begin
                ent_q <= cur_ent;
            end
            if (state_q == S_DECODE) begin
                tgt_q <= sel_tgt;
                vec_q <= ent_q.vec;
                if (sel_adv) begin
                    ofs_q <= ofs_q + OFS_W'(1);
                end
            end
            if ((state_q == S_EXT_WAIT) && ext_ack_i) begin
                vec_q <= ext_vec_i;
            end
        end
    end

    // outputs
    always_comb begin
        msg_valid_o = (state_q == S_SEND);
        ext_req_o   = (state_q == S_EXT_WAIT);
        err_o       = (state_q == S_DECODE) && sel_err;
        msg_dest_o  = ent_q.dest;
        msg_vec_o   = vec_q;
        msg_dlv_o   = ent_q.dlv;
        msg_dmode_o = ent_q.dmode;
        msg_level_o = ent_q.pol;
        msg_trig_o  = ent_q.trig;
        msg_tgt_o   = tgt_q;
    end

endmodule

// File: rtl/irq_redirect_dispatch_chk.sv
module irq_redirect_dispatch_chk
    import irq_disp_pkg::*;
#(
    parameter int NUM_TGT = 4
) (
    input logic               clk_i,
    input logic               rst_ni,
    input logic               msg_valid_o,
    input logic               msg_ready_i,
    input logic [NUM_TGT-1:0] msg_tgt_o,
    input logic [7:0]         msg_vec_o,
    input logic [7:0]         msg_dest_o,
    input logic [2:0]         msg_dlv_o,
    input logic               ext_req_o,
    input logic               ext_ack_i,
    input logic               err_o
);

    AST_LOWEST_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (msg_valid_o && msg_dlv_o == DLV_LOWEST) |-> ($countones(msg_tgt_o) == 1)); // R8

    AST_TGT_NONEMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
        msg_valid_o |-> (msg_tgt_o != '0)); // R9

    AST_STALL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (msg_valid_o && !msg_ready_i) |=> (msg_valid_o && $stable(msg_tgt_o) && $stable(msg_vec_o) && $stable(msg_dest_o))); // R11

    AST_EXT_REQ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ext_req_o && !ext_ack_i) |=> ext_req_o); // R4

    AST_ERR_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        err_o |=> !err_o); // R6

    AST_ERR_NO_MSG: assert property (@(posedge clk_i) disable iff (!rst_ni)
        err_o |-> !msg_valid_o); // R6

endmodule

bind irq_redirect_dispatch irq_redirect_dispatch_chk #(
    .NUM_TGT (NUM_TGT)
) u_chk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .msg_valid_o (msg_valid_o),
    .msg_ready_i (msg_ready_i),
    .msg_tgt_o   (msg_tgt_o),
    .msg_vec_o   (msg_vec_o),
    .msg_dest_o  (msg_dest_o),
    .msg_dlv_o   (msg_dlv_o),
    .ext_req_o   (ext_req_o),
    .ext_ack_i   (ext_ack_i),
    .err_o       (err_o)
);

// File: tb/irq_redirect_dispatch_tb.sv
module irq_redirect_dispatch_tb;

    localparam int CLK_PERIOD = 10;
    localparam int NP  = 8;
    localparam int NT  = 4;
    localparam int EW  = 23;
    localparam int WDOG = 100000;

    // row: [28:6] entry, [5] message expected, [4:1] bitmap, [0] error expected
    localparam logic [28:0] TAB [8] = '{
        {8'h02, 1'b0, 1'b0, 1'b0, 1'b0, 3'd0, 8'h31, 1'b1, 4'b0100, 1'b0}, // R5
        {8'hFF, 1'b0, 1'b0, 1'b0, 1'b0, 3'd0, 8'h32, 1'b1, 4'b1111, 1'b0}, // R5
        {8'h09, 1'b0, 1'b0, 1'b0, 1'b0, 3'd0, 8'h33, 1'b0, 4'b0000, 1'b0}, // R5
        {8'h01, 1'b1, 1'b0, 1'b0, 1'b0, 3'd0, 8'h34, 1'b0, 4'b0000, 1'b0}, // R2
        {8'h01, 1'b0, 1'b0, 1'b0, 1'b1, 3'd0, 8'h35, 1'b1, 4'b0101, 1'b0}, // R7
        {8'h40, 1'b0, 1'b0, 1'b0, 1'b1, 3'd0, 8'h36, 1'b0, 4'b0000, 1'b0}, // R9
        {8'h01, 1'b0, 1'b0, 1'b0, 1'b0, 3'd1, 8'h37, 1'b0, 4'b0000, 1'b1}, // R6
        {8'h80, 1'b0, 1'b1, 1'b1, 1'b1, 3'd0, 8'h38, 1'b1, 4'b1000, 1'b0}  // R3
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [NP-1:0]     pins = '0;
    logic [NP*EW-1:0]  redir = '0;
    logic [NT*8-1:0]   lid = {8'h80, 8'h03, 8'h02, 8'h01};
    logic              ext_req;
    logic              ext_ack = 1'b0;
    logic [7:0]        ext_vec = 8'hA5;
    logic              msg_valid;
    logic              msg_ready = 1'b1;
    logic [7:0]        msg_dest, msg_vec;
    logic [2:0]        msg_dlv;
    logic              msg_dmode, msg_level, msg_trig;
    logic [NT-1:0]     msg_tgt;
    logic              err;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    int log_n = 0;
    int err_n = 0;
    int ext_n = 0;
    logic [NT-1:0] log_tgt [16];
    logic [7:0]    log_vec [16];
    logic [7:0]    log_dest [16];
    logic [2:0]    log_dlv [16];
    logic          log_dm [16];
    logic          log_lvl [16];
    logic          log_trg [16];

    irq_redirect_dispatch #(.NUM_PINS(NP), .NUM_TGT(NT), .OFS_W(16)) u_dut (
        .clk_i(clk), .rst_ni(rst_n), .irq_pin_i(pins), .redir_tab_i(redir),
        .tgt_lid_i(lid), .ext_req_o(ext_req), .ext_ack_i(ext_ack),
        .ext_vec_i(ext_vec), .msg_valid_o(msg_valid), .msg_ready_i(msg_ready),
        .msg_dest_o(msg_dest), .msg_vec_o(msg_vec), .msg_dlv_o(msg_dlv),
        .msg_dmode_o(msg_dmode), .msg_level_o(msg_level), .msg_trig_o(msg_trig),
        .msg_tgt_o(msg_tgt), .err_o(err)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // monitor and external controller model, at the falling edge
    always @(negedge clk) begin
        if (rst_n) begin
            if (msg_valid && msg_ready && log_n < 16) begin
                log_tgt[log_n]  = msg_tgt;
                log_vec[log_n]  = msg_vec;
                log_dest[log_n] = msg_dest;
                log_dlv[log_n]  = msg_dlv;
                log_dm[log_n]   = msg_dmode;
                log_lvl[log_n]  = msg_level;
                log_trg[log_n]  = msg_trig;
                log_n++;
            end
            if (err) err_n++;
            if (ext_req) ext_n++;
            ext_ack = ext_req;
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc >= WDOG) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual %0d cycles, expected fewer than %0d", cyc, WDOG);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic clear_log();
        log_n = 0;
        err_n = 0;
        ext_n = 0;
    endtask

    task automatic set_entry(input int p, input logic [EW-1:0] e);
        redir[p*EW +: EW] = e;
    endtask

    task automatic pulse(input int p);
        step(1);
        pins[p] = 1'b1;
        step(2);
        pins[p] = 1'b0;
        step(12);
    endtask

    initial begin
        step(3);
        // R12: reset state
        chk(msg_valid == 1'b0, "R12 valid", int'(msg_valid), 0);
        chk(err == 1'b0, "R12 err", int'(err), 0);
        chk(ext_req == 1'b0, "R12 ext_req", int'(ext_req), 0);
        rst_n = 1'b1;
        step(2);

        // table walk on pin 0
        for (int i = 0; i < 8; i++) begin
            logic [EW-1:0] e;
            e = TAB[i][28:6];
            set_entry(0, e);
            clear_log();
            pulse(0);
            chk(log_n == int'(TAB[i][5]), $sformatf("R2/R5/R7/R9 row %0d count", i), log_n, int'(TAB[i][5]));
            chk(err_n == int'(TAB[i][0]), $sformatf("R6 row %0d err pulses", i), err_n, int'(TAB[i][0]));
            if (TAB[i][5] && log_n > 0) begin
                chk(log_tgt[0] == TAB[i][4:1], $sformatf("R5/R7 row %0d bitmap", i), int'(log_tgt[0]), int'(TAB[i][4:1]));
                chk(log_vec[0] == e[7:0], $sformatf("R3 row %0d vector", i), int'(log_vec[0]), int'(e[7:0]));
                chk(log_dest[0] == e[22:15], $sformatf("R3 row %0d dest", i), int'(log_dest[0]), int'(e[22:15]));
                chk(log_trg[0] == e[13], $sformatf("R3 row %0d trig", i), int'(log_trg[0]), int'(e[13]));
                chk(log_lvl[0] == e[12], $sformatf("R3 row %0d level", i), int'(log_lvl[0]), int'(e[12]));
                chk(log_dm[0] == e[11], $sformatf("R3 row %0d dmode", i), int'(log_dm[0]), int'(e[11]));
                chk(log_dlv[0] == e[10:8], $sformatf("R3 row %0d dlv", i), int'(log_dlv[0]), int'(e[10:8]));
            end
        end

        // R1: level held high, then lowered, then raised again
        set_entry(5, {8'hFF, 1'b0, 1'b0, 1'b0, 1'b0, 3'd0, 8'h50});
        clear_log();
        step(1);
        pins[5] = 1'b1;
        step(25);
        chk(log_n == 1, "R1 held high", log_n, 1);
        pins[5] = 1'b0;
        step(10);
        chk(log_n == 1, "R1 lowered", log_n, 1);
        pins[5] = 1'b1;
        step(12);
        chk(log_n == 2, "R1 re-raised", log_n, 2);
        pins[5] = 1'b0;
        step(3);

        // R4: external vector
        set_entry(4, {8'h01, 1'b0, 1'b0, 1'b0, 1'b0, 3'd7, 8'h11});
        clear_log();
        pulse(4);
        chk(log_n == 1, "R4 count", log_n, 1);
        chk(ext_n >= 1, "R4 request seen", ext_n, 1);
        chk(log_vec[0] == 8'hA5, "R4 vector", int'(log_vec[0]), 32'hA5);
        chk(log_tgt[0] == 4'b0010, "R4 bitmap", int'(log_tgt[0]), 2);

        // R8: rotation over matches t0,t1,t2
        set_entry(6, {8'h03, 1'b0, 1'b0, 1'b0, 1'b1, 3'd1, 8'h60});
        clear_log();
        for (int k = 0; k < 4; k++) pulse(6);
        chk(log_n == 4, "R8 count", log_n, 4);
        chk(log_tgt[0] == 4'b0001, "R8 pick 0", int'(log_tgt[0]), 1);
        chk(log_tgt[1] == 4'b0010, "R8 pick 1", int'(log_tgt[1]), 2);
        chk(log_tgt[2] == 4'b0100, "R8 pick 2", int'(log_tgt[2]), 4);
        chk(log_tgt[3] == 4'b0001, "R8 pick 3", int'(log_tgt[3]), 1);

        // R10: simultaneous rises on pins 3 and 1
        set_entry(1, {8'hFF, 1'b0, 1'b0, 1'b0, 1'b0, 3'd0, 8'h71});
        set_entry(3, {8'hFF, 1'b0, 1'b0, 1'b0, 1'b0, 3'd0, 8'h73});
        clear_log();
        step(1);
        pins[1] = 1'b1;
        pins[3] = 1'b1;
        step(2);
        pins[1] = 1'b0;
        pins[3] = 1'b0;
        step(15);
        chk(log_n == 2, "R10 count", log_n, 2);
        chk(log_vec[0] == 8'h71, "R10 first", int'(log_vec[0]), 32'h71);
        chk(log_vec[1] == 8'h73, "R10 second", int'(log_vec[1]), 32'h73);

        // R11: stall holds the message
        set_entry(2, {8'h03, 1'b0, 1'b0, 1'b0, 1'b0, 3'd0, 8'h22});
        clear_log();
        msg_ready = 1'b0;
        pulse(2);
        chk(msg_valid == 1'b1, "R11 valid held", int'(msg_valid), 1);
        chk(msg_vec == 8'h22, "R11 vector held", int'(msg_vec), 32'h22);
        chk(msg_tgt == 4'b1000, "R11 bitmap held", int'(msg_tgt), 8);
        chk(log_n == 0, "R11 nothing taken", log_n, 0);
        msg_ready = 1'b1;
        step(3);
        chk(log_n == 1, "R11 released", log_n, 1);
        chk(msg_valid == 1'b0, "R11 valid dropped", int'(msg_valid), 0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule